// File: doc/BRIEF.md
# Amplifier Mode and Power Controller

This block keeps the operating configuration of a digital-input class-D amplifier and steps it through its power states. While reset is held it captures the default gain and oversampling rate from a 2-bit code that an analog sensor derives from a four-state configuration pin. After reset it keeps those defaults fixed. Command bytes arrive as strobes from an upstream pattern detector. Some of them change the gain, the rate, the EMI mode, the low-latency mode or the mute flag. Another restores the defaults, and another requests standby.

The block runs on a free-running reference clock. The PDM bit clock arrives as a toggle level, `pclk_tgl`, which the PDM domain flips on every bit-clock edge. The block synchronises this level and times the gaps between toggles. A gap longer than the limit counts as clock loss and forces full power-down. Power-down throws away every override. The block wakes from standby or from power-down when a non-stop input is reported, and power-down additionally requires the clock to be back.

Top module: `amp_mode_ctrl`

## Requirements
- R1: Strap decode: code 2'b00 gives 64x rate with 3.6 V gain, 2'b01 gives 64x with 5 V gain, 2'b10 gives 128x with 5 V gain, and 2'b11 gives 128x with 3.6 V gain. `gain_sel` uses 2'b00 for 3.6 V, 2'b01 for 5 V and 2'b10 for 2.5 V. `rate_128` is 1 for 128x.
- R2: The strap code is sampled only while `rst` is high. A later change of `strap_code` does not affect the defaults restored by command 8'hAA or by a wake from power-down.
- R3: In run, command 8'hD2 selects 3.6 V gain, 8'hD4 selects 2.5 V gain and 8'hD8 selects 5 V gain. An unlisted code changes nothing.
- R4: In run, command 8'hE4 sets the rate to the inverse of the strap rate, and repeating it keeps that value. Command 8'hAA restores the strap gain and rate, and clears the EMI, low-latency and mute flags.
- R5: In run, 8'hE1 sets `emi_low`, 8'hE2 sets `low_lat` and 8'h66 sets `mute`. Each flag stays set until a restore or a power-down.
- R6: In run, command 8'hAC moves `pwr_state` from 2'b00 (run) to 2'b01 (standby). Commands received outside run are ignored.
- R7: In standby, a `data_active` strobe returns the block to run, keeps the configuration, and clears `mute`. Every entry into run leaves `mute` at 0.
- R8: If no toggle of `pclk_tgl` is seen for LOSS_CYCLES reference cycles, the block moves from run or standby to 2'b10 (power-down). All outputs then return to the strap defaults with every flag cleared.
- R9: The block leaves power-down for run only when `data_active` arrives while the bit clock is toggling. It never goes straight from power-down to standby.
- R10: After reset `pwr_state` is 2'b00 with the strap defaults and all flags at 0. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| strap_code | input | 2 | Decoded four-state configuration pin |
| pclk_tgl | input | 1 | Level toggled on each PDM clock edge (asynchronous) |
| cmd_valid | input | 1 | One-cycle strobe: a command byte was recognised |
| cmd_code | input | 8 | Recognised command byte |
| data_active | input | 1 | One-cycle strobe: a non-stop input was received |
| pwr_state | output | 2 | 00 run, 01 standby, 10 power-down |
| gain_sel | output | 2 | 00 3.6 V, 01 5 V, 10 2.5 V |
| rate_128 | output | 1 | 1 selects 128x, 0 selects 64x |
| emi_low | output | 1 | Low-emission modulation enabled |
| low_lat | output | 1 | Low-latency filtering enabled |
| mute | output | 1 | Output muted |

## Verification
A corrupted strap register shows up at the ports only when defaults are restored: after command 8'hAA, or after a clock-loss power-down and wake. The tests therefore change the strap code after reset and then force both kinds of restore. A gap counter that sticks shows up as a missed power-down about LOSS_CYCLES plus a few synchroniser cycles after the toggles stop. A counter that clears too early shows up as an early power-down while the clock is still running. Errors in the state or flag registers appear on the outputs one cycle after the strobe that causes them. The tests sample right after that cycle.

// File: rtl/amp_mode_pkg.sv
package amp_mode_pkg;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'b00,
    PWR_STBY = 2'b01,
    PWR_OFF  = 2'b10
  } pwr_e;

  localparam logic [1:0] GAIN_3V6 = 2'b00;
  localparam logic [1:0] GAIN_5V0 = 2'b01;
  localparam logic [1:0] GAIN_2V5 = 2'b10;

  localparam logic [7:0] OP_GAIN_3V6  = 8'hD2;
  localparam logic [7:0] OP_GAIN_2V5  = 8'hD4;
  localparam logic [7:0] OP_GAIN_5V0  = 8'hD8;
  localparam logic [7:0] OP_EMI       = 8'hE1;
  localparam logic [7:0] OP_LOWLAT    = 8'hE2;
  localparam logic [7:0] OP_RATE_FLIP = 8'hE4;
  localparam logic [7:0] OP_RESTORE   = 8'hAA;
  localparam logic [7:0] OP_MUTE      = 8'h66;
  localparam logic [7:0] OP_STOP      = 8'hAC;

  typedef struct packed {
    logic [1:0] gain;
    logic       rate_128;
  } cfg_dflt_t;

  // bit1 selects the pull direction (rate), bit0 xor bit1 marks a resistor strap (5 V gain)
  function automatic cfg_dflt_t strap_decode(input logic [1:0] code);
    cfg_dflt_t d;
    d.rate_128 = code[1];
    d.gain     = (code[1] ^ code[0]) ? GAIN_5V0 : GAIN_3V6;
    return d;
  endfunction

endpackage

// File: rtl/amp_strap_latch.sv
module amp_strap_latch
  import amp_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_code,
  output cfg_dflt_t  dflt
);

  cfg_dflt_t held_q;

  always_ff @(posedge clk) begin
    if (rst) held_q <= strap_decode(strap_code);
  end

  // during reset the live decode is forwarded so reset values are valid on the first edge
  assign dflt = rst ? strap_decode(strap_code) : held_q;

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(dflt)); // R2

endmodule

// File: rtl/amp_clk_monitor.sv
module amp_clk_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic pclk_tgl,
  output logic pclk_lost
);

  localparam int CNT_W = $clog2(LOSS_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOSS_CYCLES);

  logic [SYNC_STAGES:0] sync_q;
  logic [CNT_W-1:0]     idle_q;
  logic                 edge_seen;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], pclk_tgl};
  end

  assign edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)                idle_q <= '0;
    else if (edge_seen)     idle_q <= '0;
    else if (idle_q != LIMIT) idle_q <= idle_q + 1'b1;
  end

  assign pclk_lost = (idle_q == LIMIT);

  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    idle_q <= LIMIT); // R8
  AST_EDGE_CLEARS_LOSS: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> !pclk_lost); // R8

endmodule

// File: rtl/amp_pwr_fsm.sv
module amp_pwr_fsm
  import amp_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       data_active,
  input  logic       pclk_lost,
  output pwr_e       state,
  output logic       cfg_restore,
  output logic       run_entry,
  output logic       cmd_en
);

  pwr_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      PWR_RUN: begin
        if (pclk_lost)                              nxt = PWR_OFF;
        else if (cmd_valid && cmd_code == OP_STOP)  nxt = PWR_STBY;
      end
      PWR_STBY: begin
        if (pclk_lost)        nxt = PWR_OFF;
        else if (data_active) nxt = PWR_RUN;
      end
      PWR_OFF: begin
        if (data_active && !pclk_lost) nxt = PWR_RUN;
      end
      default: nxt = PWR_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PWR_RUN;
    else     state <= nxt;
  end

  assign cmd_en      = (state == PWR_RUN) && !pclk_lost;
  assign cfg_restore = (nxt == PWR_OFF) && (state != PWR_OFF);
  assign run_entry   = (nxt == PWR_RUN) && (state != PWR_RUN);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state != 2'b11); // R10
  AST_LOSS_POWERS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (state != PWR_OFF && pclk_lost) |=> state == PWR_OFF); // R8
  AST_OFF_NO_STANDBY: assert property (@(posedge clk) disable iff (rst)
    state == PWR_OFF |=> state != PWR_STBY); // R9
  AST_STOP_TO_STANDBY: assert property (@(posedge clk) disable iff (rst)
    (state == PWR_RUN && !pclk_lost && cmd_valid && cmd_code == OP_STOP) |=> state == PWR_STBY); // R6

endmodule

// File: rtl/amp_mode_regs.sv
module amp_mode_regs
  import amp_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cfg_dflt_t  dflt,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       cmd_en,
  input  logic       cfg_restore,
  input  logic       run_entry,
  output logic [1:0] gain_sel,
  output logic       rate_128,
  output logic       emi_low,
  output logic       low_lat,
  output logic       mute
);

  logic take_cmd;
  assign take_cmd = cmd_valid && cmd_en;

  always_ff @(posedge clk) begin
    if (rst || cfg_restore) begin
      gain_sel <= dflt.gain;
      rate_128 <= dflt.rate_128;
      emi_low  <= 1'b0;
      low_lat  <= 1'b0;
      mute     <= 1'b0;
    end else begin
      if (run_entry) mute <= 1'b0;
      if (take_cmd) begin
        case (cmd_code)
          OP_GAIN_3V6:  gain_sel <= GAIN_3V6;
          OP_GAIN_2V5:  gain_sel <= GAIN_2V5;
          OP_GAIN_5V0:  gain_sel <= GAIN_5V0;
          OP_EMI:       emi_low  <= 1'b1;
          OP_LOWLAT:    low_lat  <= 1'b1;
          OP_RATE_FLIP: rate_128 <= ~dflt.rate_128;
          OP_MUTE:      mute     <= 1'b1;
          OP_RESTORE: begin
            gain_sel <= dflt.gain;
            rate_128 <= dflt.rate_128;
            emi_low  <= 1'b0;
            low_lat  <= 1'b0;
            mute     <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  AST_RATE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (take_cmd && cmd_code == OP_RATE_FLIP && !cfg_restore) |=> rate_128 != dflt.rate_128); // R4
  AST_MUTE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mute && !cfg_restore && !run_entry && !(take_cmd && cmd_code == OP_RESTORE)) |=> mute); // R5

endmodule

// File: rtl/amp_mode_ctrl.sv
module amp_mode_ctrl
  import amp_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_code,
  input  logic       pclk_tgl,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       data_active,
  output logic [1:0] pwr_state,
  output logic [1:0] gain_sel,
  output logic       rate_128,
  output logic       emi_low,
  output logic       low_lat,
  output logic       mute
);

  cfg_dflt_t dflt;
  pwr_e      state;
  logic      pclk_lost, cfg_restore, run_entry, cmd_en;

  amp_strap_latch u_strap (
    .clk        (clk),
    .rst        (rst),
    .strap_code (strap_code),
    .dflt       (dflt)
  );

  amp_clk_monitor #(
    .SYNC_STAGES (SYNC_STAGES),
    .LOSS_CYCLES (LOSS_CYCLES)
  ) u_mon (
    .clk       (clk),
    .rst       (rst),
    .pclk_tgl  (pclk_tgl),
    .pclk_lost (pclk_lost)
  );

  amp_pwr_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .data_active (data_active),
    .pclk_lost   (pclk_lost),
    .state       (state),
    .cfg_restore (cfg_restore),
    .run_entry   (run_entry),
    .cmd_en      (cmd_en)
  );

  amp_mode_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .dflt        (dflt),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_en      (cmd_en),
    .cfg_restore (cfg_restore),
    .run_entry   (run_entry),
    .gain_sel    (gain_sel),
    .rate_128    (rate_128),
    .emi_low     (emi_low),
    .low_lat     (low_lat),
    .mute        (mute)
  );

  assign pwr_state = state;

  AST_OFF_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    state == PWR_OFF |-> (gain_sel == dflt.gain && rate_128 == dflt.rate_128
                          && !emi_low && !low_lat && !mute)); // R8
  AST_RUN_ENTRY_UNMUTED: assert property (@(posedge clk) disable iff (rst)
    (state == PWR_RUN && $past(state) != PWR_RUN) |-> !mute); // R7

endmodule

// File: tb/tb_amp_mode_ctrl.sv
module tb_amp_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LOSS = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] strap_code = 2'b00;
  logic       pclk_tgl = 1'b0;
  logic       pclk_on = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic       data_active = 1'b0;
  logic [1:0] pwr_state, gain_sel;
  logic       rate_128, emi_low, low_lat, mute;

  int n_chk = 0;
  int n_bad = 0;

  amp_mode_ctrl #(.SYNC_STAGES(2), .LOSS_CYCLES(LOSS)) dut (
    .clk(clk), .rst(rst), .strap_code(strap_code), .pclk_tgl(pclk_tgl),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .data_active(data_active),
    .pwr_state(pwr_state), .gain_sel(gain_sel), .rate_128(rate_128),
    .emi_low(emi_low), .low_lat(low_lat), .mute(mute)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    repeat (2) @(negedge clk);
    if (pclk_on) pclk_tgl = ~pclk_tgl;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_cfg(input string req, input logic [1:0] st, input logic [1:0] g,
                           input logic r, input logic e, input logic l, input logic m);
    chk({req, " state"}, {6'd0, pwr_state}, {6'd0, st});
    chk({req, " gain"},  {6'd0, gain_sel},  {6'd0, g});
    chk({req, " rate"},  {7'd0, rate_128},  {7'd0, r});
    chk({req, " emi"},   {7'd0, emi_low},   {7'd0, e});
    chk({req, " lat"},   {7'd0, low_lat},   {7'd0, l});
    chk({req, " mute"},  {7'd0, mute},      {7'd0, m});
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge clk);
    rst = 1'b1;
    strap_code = code;
    pclk_on = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] code);
    cmd_valid = 1'b1;
    cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code = 8'h00;
  endtask

  task automatic pulse_data();
    data_active = 1'b1;
    @(negedge clk);
    data_active = 1'b0;
  endtask

  task automatic t_strap_decode();
    do_reset(2'b00); check_cfg("R1 R10 tie-low",   2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    do_reset(2'b01); check_cfg("R1 weak-low",      2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    do_reset(2'b10); check_cfg("R1 weak-high",     2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
    do_reset(2'b11); check_cfg("R1 tie-high",      2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_gain_cmds();
    do_reset(2'b01);
    send(8'hD4); chk("R3 gain 2.5", {6'd0, gain_sel}, 8'h02);
    send(8'hD2); chk("R3 gain 3.6", {6'd0, gain_sel}, 8'h00);
    send(8'hD8); chk("R3 gain 5",   {6'd0, gain_sel}, 8'h01);
    send(8'h55); check_cfg("R3 unlisted", 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_rate_and_restore();
    do_reset(2'b01);
    send(8'hE4); chk("R4 rate flip",   {7'd0, rate_128}, 8'h01);
    send(8'hE4); chk("R4 rate repeat", {7'd0, rate_128}, 8'h01);
    send(8'hD4); send(8'hE1); send(8'hE2); send(8'h66);
    check_cfg("R5 flags set", 2'b00, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    check_cfg("R5 flags sticky", 2'b00, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1);
    send(8'hAA);
    check_cfg("R4 restore", 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_strap_frozen();
    do_reset(2'b01);
    strap_code = 2'b10;
    send(8'hD4); send(8'hE4);
    send(8'hAA);
    check_cfg("R2 restore ignores new strap", 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_standby();
    do_reset(2'b11);
    send(8'hE1); send(8'h66);
    send(8'hAC);
    chk("R6 stop to standby", {6'd0, pwr_state}, 8'h01);
    send(8'hD4); send(8'hE2);
    check_cfg("R6 commands ignored in standby", 2'b01, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1);
    pulse_data();
    check_cfg("R7 wake keeps cfg, unmutes", 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_loss_from_run();
    do_reset(2'b10);
    strap_code = 2'b00;
    send(8'hD4); send(8'hE2); send(8'hE4); send(8'h66);
    repeat (LOSS - 4) @(negedge clk);
    chk("R8 no loss while clocked", {6'd0, pwr_state}, 8'h00);
    pclk_on = 1'b0;
    repeat (LOSS + 14) @(negedge clk);
    check_cfg("R8 loss from run", 2'b10, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
    send(8'hD2);
    pulse_data();
    check_cfg("R9 no wake without clock", 2'b10, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
    pclk_on = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 clock back, still off", {6'd0, pwr_state}, 8'h02);
    pulse_data();
    check_cfg("R9 R2 wake with strap defaults", 2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_loss_from_standby();
    do_reset(2'b00);
    send(8'hE1);
    send(8'hAC);
    chk("R6 standby entered", {6'd0, pwr_state}, 8'h01);
    pclk_on = 1'b0;
    repeat (LOSS + 14) @(negedge clk);
    check_cfg("R8 loss from standby", 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    pclk_on = 1'b1;
    repeat (8) @(negedge clk);
    pulse_data();
    chk("R9 wake from off", {6'd0, pwr_state}, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_strap_decode();
    t_gain_cmds();
    t_rate_and_restore();
    t_strap_frozen();
    t_standby();
    t_loss_from_run();
    t_loss_from_standby();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule